// File: doc/BRIEF.md
# Delay-Range Sequence Matcher

This block watches a set of sampled expressions and recognises the temporal pattern "first expression true, then the second expression true some number of cycles later, within a window". The window's lower bound, its upper bound and an open-ended upper bound are chosen by parameters. The block is a one-hot, non-deterministic automaton, so an attempt can start on every cycle and many attempts can be in flight at once. Each attempt is tracked as a token moving down a chain of state flops.

Attempts begin only on cycles where the start input is high. A disable input clears every attempt that is alive in that cycle. A guard input must hold in every cycle of an attempt, from its first cycle to its last. The result passes through one output register. In assert mode the flag sits at 1 and drops to 0 in the cycle after a complete match, which marks the pattern as forbidden. In cover mode the flag sits at 0 and rises to 1 in the cycle after a match.

Top module: `dly_seq_monitor`

## Requirements
- R1: When the synchronised reset ends, `flag_o` is 1 in assert mode (MODE = MODE_ASSERT) and 0 in cover mode (MODE = MODE_COVER). It holds that value while no match occurs.
- R2: An attempt that starts in cycle t0 has start_i, first_i and guard_i high in t0. If second_i and guard_i are high in cycle t0+k with MIN_DLY ≤ k ≤ MAX_DLY, that is a match. This holds at both edges of the window.
- R3: When k < MIN_DLY, or k > MAX_DLY with OPEN_END = 0, no match is produced.
- R4: Overlapping attempts, started on consecutive or interleaved cycles, are each judged on their own. A match by any one of them is enough.
- R5: When dis_i is high in any cycle from t0 to t0+k, that attempt cannot match.
- R6: When guard_i is low in any cycle from t0 to t0+k, that attempt cannot match.
- R7: With OPEN_END = 1, every delay k ≥ MIN_DLY matches, however large.
- R8: With MIN_DLY = 0, start_i, first_i and second_i high in one cycle is a match in that same cycle.
- R9: `flag_o` in a cycle depends only on whether a match occurred in the previous cycle. In assert mode it is the inverse of that match; in cover mode it equals that match.
- R10: A cycle with first_i high and start_i low begins no attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Lets an attempt begin in this cycle |
| dis_i | input | 1 | Clears every live attempt in this cycle |
| guard_i | input | 1 | Condition that must hold in every cycle of an attempt |
| first_i | input | 1 | Opening expression of the pattern |
| second_i | input | 1 | Closing expression of the pattern |
| flag_o | output | 1 | Registered result: okay flag (assert) or hit flag (cover) |

## Verification
The collisions that matter are an attempt ending in the same cycle that another begins, and a disable or guard drop that falls in the exact cycle where a token would complete. The bench drives dense stretches in which start_i, second_i and dis_i pulse together. It also sends directed attempts that put the disable or the guard drop on the first cycle, a middle cycle and the closing cycle. A reference model in the bench lists every possible start cycle for each cycle. It judges each candidate against the window bounds and the guard and disable history, then compares the predicted flag with the output one cycle later. Three instances with different bounds and modes are checked on the same stimulus.

// File: rtl/dly_seq_pkg.sv
package dly_seq_pkg;

  typedef enum logic {
    MODE_ASSERT = 1'b0,
    MODE_COVER  = 1'b1
  } mon_mode_e;

  // number of delay stages after the opening node
  function automatic int chain_len(input int lo, input int hi, input bit open_end);
    return open_end ? lo : hi;
  endfunction

endpackage

// File: rtl/dly_seq_rst_sync.sv
module dly_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_q_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_no = sync_q[STAGES-1];

endmodule

// File: rtl/dly_seq_stage.sv
module dly_seq_stage #(
  parameter bit EDGE_EN = 1'b1,
  parameter bit LINK_EN = 1'b0,
  parameter bit SELF_EN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_i,
  input  logic guard_i,
  input  logic edge_src_i,
  input  logic link_src_i,
  output logic state_o,
  output logic q_o
);

  logic d;
  logic upd;
  logic link_term;
  logic edge_term;
  logic self_term;

  // token arriving through a zero-delay bypass in this cycle
  assign link_term = link_src_i & LINK_EN & guard_i;
  assign state_o   = (q_o & ~dis_i) | link_term;

  // tokens that move on at the next clock
  always_comb begin
    edge_term = edge_src_i & EDGE_EN & guard_i;
    self_term = state_o & SELF_EN & guard_i;
    d         = edge_term | self_term;
    upd       = d | q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else if (upd) begin
      q_o <= d;
    end
  end

  // R5
  stage_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !q_o);

  // R6
  stage_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !guard_i |=> !q_o);

  // R2
  stage_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o |-> $past((edge_src_i & EDGE_EN) | (state_o & SELF_EN)));

endmodule

// File: rtl/dly_seq_monitor.sv
module dly_seq_monitor
  import dly_seq_pkg::*;
#(
  parameter int        MIN_DLY  = 2,
  parameter int        MAX_DLY  = 5,
  parameter bit        OPEN_END = 1'b0,
  parameter mon_mode_e MODE     = MODE_ASSERT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dis_i,
  input  logic guard_i,
  input  logic first_i,
  input  logic second_i,
  output logic flag_o
);

  localparam int NST       = chain_len(MIN_DLY, MAX_DLY, OPEN_END);
  localparam bit NODE0_FF  = OPEN_END && (MIN_DLY == 0);
  localparam bit FLAG_IDLE = (MODE == MODE_ASSERT);

  logic           rst_q_n;
  logic           start_state;
  logic [NST:0]   st;
  logic [NST:0]   chain_q;
  logic           accept;
  logic           flag_d;

  dly_seq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_q_no (rst_q_n)
  );

  // start node: it has no incoming edge, so no flop
  assign start_state = start_i & ~dis_i;

  // node 0 holds the cycle where the opening expression was seen
  generate
    if (NODE0_FF) begin : g_node0_ff
      dly_seq_stage #(.EDGE_EN(1'b0), .LINK_EN(1'b1), .SELF_EN(1'b1)) i_node0 (
        .clk_i      (clk_i),
        .rst_ni     (rst_q_n),
        .dis_i      (dis_i),
        .guard_i    (guard_i),
        .edge_src_i (1'b0),
        .link_src_i (start_state & first_i),
        .state_o    (st[0]),
        .q_o        (chain_q[0])
      );
    end else begin : g_node0_comb
      assign st[0]      = start_state & first_i & guard_i;
      assign chain_q[0] = 1'b0;
    end

    for (genvar k = 1; k <= NST; k++) begin : g_chain
      localparam bit OPT_STAGE = !OPEN_END && (k > MIN_DLY);
      localparam bit LOOP_ST   = OPEN_END && (k == MIN_DLY);
      dly_seq_stage #(.EDGE_EN(1'b1), .LINK_EN(OPT_STAGE), .SELF_EN(LOOP_ST)) i_stage (
        .clk_i      (clk_i),
        .rst_ni     (rst_q_n),
        .dis_i      (dis_i),
        .guard_i    (guard_i),
        .edge_src_i (st[k-1]),
        .link_src_i (st[k-1]),
        .state_o    (st[k]),
        .q_o        (chain_q[k])
      );
    end
  endgenerate

  // closing expression, then accept; the guard is in every link
  assign accept = st[NST] & second_i & guard_i;

  always_comb begin
    if (MODE == MODE_ASSERT) begin
      flag_d = ~accept;
    end else begin
      flag_d = accept;
    end
  end

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flag_o <= FLAG_IDLE;
    end else begin
      flag_o <= flag_d;
    end
  end

  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (!start_i && (chain_q == '0)) |-> !accept);

  // R5
  dis_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    dis_i |-> !accept);

  generate
    if (MODE == MODE_ASSERT) begin : g_chk_assert
      // R9
      flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
        !flag_o |-> $past(second_i && guard_i && !dis_i));
    end else begin : g_chk_cover
      // R9
      flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
        flag_o |-> $past(second_i && guard_i && !dis_i));
    end
  endgenerate

  initial begin
    // R3
    bounds_chk: assert (MIN_DLY >= 0 && MIN_DLY <= MAX_DLY && MAX_DLY <= 8);
  end

endmodule

// File: tb/test_dly_seq_monitor.sv
`timescale 1ns/1ps
module test_dly_seq_monitor;
  import dly_seq_pkg::*;

  localparam int NC = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_t = 1'b0, s_d = 1'b0, s_g = 1'b1, s_a = 1'b0, s_b = 1'b0;
  logic f_as, f_cv, f_inf;

  always #2.5 clk = ~clk;

  dly_seq_monitor #(.MIN_DLY(2), .MAX_DLY(5), .OPEN_END(1'b0), .MODE(MODE_ASSERT)) i_dly_seq_monitor (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_t), .dis_i(s_d), .guard_i(s_g),
    .first_i(s_a), .second_i(s_b), .flag_o(f_as));

  dly_seq_monitor #(.MIN_DLY(0), .MAX_DLY(3), .OPEN_END(1'b0), .MODE(MODE_COVER)) i_dly_seq_monitor_cov (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_t), .dis_i(s_d), .guard_i(s_g),
    .first_i(s_a), .second_i(s_b), .flag_o(f_cv));

  dly_seq_monitor #(.MIN_DLY(3), .MAX_DLY(3), .OPEN_END(1'b1), .MODE(MODE_COVER)) i_dly_seq_monitor_inf (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_t), .dis_i(s_d), .guard_i(s_g),
    .first_i(s_a), .second_i(s_b), .flag_o(f_inf));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit pend = 1'b0;
  string tag = "R1";
  bit h_t[NC], h_a[NC], h_b[NC], h_g[NC], h_d[NC];
  logic e_as, e_cv, e_inf;

  function automatic bit model(input int t, input int lo, input int hi, input bit open_end);
    bit hit = 1'b0;
    for (int k = 0; k <= t; k++) begin
      if (!h_g[t-k] || h_d[t-k]) break;
      if (k >= lo && (open_end || k <= hi) && h_t[t-k] && h_a[t-k]) hit = 1'b1;
    end
    return hit && h_b[t];
  endfunction

  task automatic chk(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%b expected=%b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit a, input bit b, input bit g, input bit d);
    @(negedge clk);
    if (pend) begin
      chk("assert_lo2_hi5", f_as, e_as);
      chk("cover_lo0_hi3", f_cv, e_cv);
      chk("cover_lo3_open", f_inf, e_inf);
    end
    s_t = t; s_a = a; s_b = b; s_g = g; s_d = d;
    if (cyc < NC) begin
      h_t[cyc] = t; h_a[cyc] = a; h_b[cyc] = b; h_g[cyc] = g; h_d[cyc] = d;
      e_as  = ~model(cyc, 2, 5, 1'b0);
      e_cv  = model(cyc, 0, 3, 1'b0);
      e_inf = model(cyc, 3, 3, 1'b1);
      pend  = 1'b1;
      cyc++;
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  // start at offset 0, close at offset k; optional disable / guard drop
  task automatic attempt(input int k, input int dis_at, input int gl_at);
    for (int i = 0; i <= k; i++)
      step(i == 0, i == 0, i == k, gl_at != i, dis_at == i);
    gap(8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R1";
    chk("reset_assert", f_as, 1'b1);
    chk("reset_cover", f_cv, 1'b0);
    chk("reset_open", f_inf, 1'b0);
    gap(3);

    tag = "R2"; attempt(2, -1, -1); attempt(5, -1, -1); attempt(3, -1, -1);
    tag = "R8"; attempt(0, -1, -1);
    tag = "R3"; attempt(1, -1, -1); attempt(6, -1, -1); attempt(7, -1, -1);
    tag = "R5"; attempt(4, 0, -1); attempt(4, 2, -1); attempt(4, 4, -1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1); gap(2);
    tag = "R6"; attempt(3, -1, 0); attempt(3, -1, 1); attempt(3, -1, 3);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0); gap(2);
    tag = "R7"; attempt(12, -1, -1); attempt(30, -1, -1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1); gap(2);
    tag = "R10";
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    gap(2);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    gap(8);
    tag = "R4";
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, (i % 3) == 2, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) step(i % 2 == 0, 1'b1, i % 4 == 1, 1'b1, i == 7);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1); gap(8);

    tag = "R9";
    for (int p = 0; p < 3; p++) begin
      int dens;
      dens = 20 + p * 30;
      for (int i = 0; i < 900; i++)
        step($urandom_range(99) < dens, $urandom_range(99) < 60,
             $urandom_range(99) < dens, $urandom_range(99) < 92,
             $urandom_range(99) < 4);
    end
    @(negedge clk);
    if (pend) begin
      chk("assert_lo2_hi5", f_as, e_as);
      chk("cover_lo0_hi3", f_cv, e_cv);
      chk("cover_lo3_open", f_inf, e_inf);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule